// File: doc/BRIEF.md
# Two-Wire Bus Master Controller

This block drives a two-wire open-drain serial bus (one clock line, one data line) as a bus master. A host hands it one command at a time through a valid/ready pair: take the bus, write a byte, read a byte while answering ACK or NACK, or release the bus. When the command is done, the block pulses a response carrying the received byte, the acknowledge bit seen on the line, an extended-address flag and a lost flag. Each line is driven only low, through an output enable. Its level comes back on a line input that passes through a two-flop synchronizer.

Bit timing comes from a quarter-phase tick generator. One tick fires every `div+1` clock cycles, and one bit takes four ticks. Data is set up in phase 0, the clock is released in phase 1, the data line is sampled in phase 2 and the clock is pulled low in phase 3. The `div` input must be at least 3, so that a line change has crossed the synchronizer before it is sampled. It must be held steady while a command runs.

The controller has six states, each named here with its transitions. IDLE waits for a command. BEGIN runs a start condition on a free bus. RESUME runs a repeated start on a bus the controller already holds. SHIFT moves nine bits, eight data bits and one acknowledge bit. END runs a stop condition. REPLY is the single-cycle response state. The transitions are these. IDLE→BEGIN is a start command on a free bus. IDLE→RESUME is a start command while the bus is held. IDLE→SHIFT is a write or read command while the bus is held. IDLE→END is a stop command while the bus is held. IDLE→REPLY is a command that cannot run. BEGIN, RESUME and END go to REPLY after phase 3. SHIFT goes to REPLY after the ninth bit, or at once when arbitration is lost. REPLY→IDLE always follows.

Top module: `twi_master`

## Requirements
- R1: After reset, both line enables are low, `cmd_ready` is high and `rsp_valid` is low.
- R2: A start command on a free bus (both synchronized lines high) pulls the data line low while the clock line is high, then pulls the clock line low. It completes with `rsp_lost`=0.
- R3: Outside start and stop conditions, the data line changes only while the clock line is low. Every transfer therefore adds no start or stop condition on the bus.
- R4: A write command (`cmd_op`=2) sends `cmd_data` most significant bit first, then releases the data line for a ninth bit. The level sampled on that bit is returned in `rsp_nack` (0 = ACK, 1 = NACK).
- R5: A read command keeps the data line released for eight bits and returns them in `rsp_data`, first bit in bit 7. On the ninth bit it drives ACK (0) for `cmd_op`=3 and NACK (1) for `cmd_op`=4.
- R6: A start command while the bus is held performs a repeated start. The data line falls while the clock is high, and no stop condition is made.
- R7: A stop command (`cmd_op`=5) raises the clock line first and then the data line. After it, both lines are released.
- R8: `rsp_ext` is 1 for the first write after a start or repeated start whose `cmd_data[7:3]` is 11110. It is 0 for every other response.
- R9: If the controller releases the data line to send a 1 in a bit it drives but samples 0 in phase 2, it releases both lines at once. It then responds with `rsp_lost`=1, gives up the bus and returns to IDLE.
- R10: Each quarter phase lasts `div+1` clock cycles, so the clock line stays high for 2·(`div+1`) cycles in each data bit.
- R11: A write, read or stop command while the bus is not held completes at once with `rsp_nack`=1 and no line activity. `cmd_valid` pulses while `cmd_ready` is low are ignored. `cmd_op` values 0, 6 and 7 are ignored.
- R12: A start command while the bus is not free completes at once with `rsp_lost`=1 and leaves both lines released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div | input | DIV_W | Quarter-phase length minus one (at least 3) |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 3 | 1 start, 2 write, 3 read+ACK, 4 read+NACK, 5 stop |
| cmd_data | input | 8 | Byte to write |
| cmd_ready | output | 1 | Controller idle, command accepted |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 8 | Byte read |
| rsp_nack | output | 1 | Acknowledge bit seen, or command rejected |
| rsp_ext | output | 1 | Extended-address prefix written |
| rsp_lost | output | 1 | Arbitration lost or bus busy at start |
| scl_in | input | 1 | Clock line level |
| scl_oe | output | 1 | Pull clock line low |
| sda_in | input | 1 | Data line level |
| sda_oe | output | 1 | Pull data line low |

## Verification
A peripheral model on the bench rebuilds the wired-AND lines, counts start and stop conditions, captures written bytes and answers reads. Seeded random transactions vary the address, the direction, the byte count, the data, the peripheral's ACK/NACK choice, the divider, and whether each transaction ends with a stop or a repeated start. Comparing the exact start and stop counts separates a correct bit phase from a stray edge on the data line while the clock is high. Matching the captured byte with the response byte shows whether the shift order is right. Directed cases cover the extended-address prefix on the first and on later bytes, a rival master forcing a 0 under a 1, a start on a held-low bus, commands with no bus held, and a command pulse during a transfer.

// File: rtl/twi_pkg.sv
`timescale 1ns/1ps
package twi_pkg;
    typedef enum logic [2:0] {
        OP_NOP       = 3'd0,
        OP_START     = 3'd1,
        OP_WRITE     = 3'd2,
        OP_READ_ACK  = 3'd3,
        OP_READ_NACK = 3'd4,
        OP_STOP      = 3'd5
    } twi_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BEGIN,
        ST_RESUME,
        ST_SHIFT,
        ST_END,
        ST_REPLY
    } twi_state_e;

    localparam logic [4:0] EXT_PREFIX = 5'b11110;
endpackage

// File: rtl/twi_sync.sv
`timescale 1ns/1ps
module twi_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] synced
);
    logic [LINES-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '1;
                else if (s == 0) chain[s] <= raw;
                else chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign synced = chain[STAGES-1];
endmodule

// File: rtl/twi_qtick.sv
`timescale 1ns/1ps
module twi_qtick #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (!run || cnt == '0)  cnt <= div;
        else                         cnt <= cnt - 1'b1;
    end

    assign tick = run && (cnt == '0);

    // R10: with a non-zero divider, two ticks never fall in adjacent cycles
    p_tick_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0 && $stable(div)) |=> !tick);
endmodule

// File: rtl/twi_master.sv
`timescale 1ns/1ps
module twi_master
    import twi_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [7:0]       cmd_data,
    output logic             cmd_ready,
    output logic             rsp_valid,
    output logic [7:0]       rsp_data,
    output logic             rsp_nack,
    output logic             rsp_ext,
    output logic             rsp_lost,
    input  logic             scl_in,
    output logic             scl_oe,
    input  logic             sda_in,
    output logic             sda_oe
);
    localparam int BITS = 9;
    localparam int BW   = $clog2(BITS);

    twi_state_e     state, state_d;
    twi_op_e        op;
    logic [1:0]     ph;
    logic [BW-1:0]  bitn;
    logic [8:0]     txsr;
    logic [7:0]     rxsr;
    logic           rd, owned, first;
    logic           lost_q, nack_q, ext_q;
    logic           tick, run, scl_s, sda_s, bus_idle, drive_bit, arb_lose, accept;

    twi_sync #(.STAGES(2), .LINES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw({scl_in, sda_in}), .synced({scl_s, sda_s})
    );

    assign run = (state == ST_BEGIN) || (state == ST_RESUME) ||
                 (state == ST_SHIFT) || (state == ST_END);

    twi_qtick #(.DIV_W(DIV_W)) u_qtick (
        .clk(clk), .rst_n(rst_n), .run(run), .div(div), .tick(tick)
    );

    assign op        = twi_op_e'(cmd_op);
    assign bus_idle  = scl_s && sda_s;
    assign accept    = (state == ST_IDLE) && cmd_valid;
    assign drive_bit = rd ? (bitn == '0) : (bitn != '0);
    assign arb_lose  = drive_bit && txsr[8] && !sda_s;

    // next-state logic
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: if (cmd_valid) begin
                case (op)
                    OP_START:     state_d = owned ? ST_RESUME : (bus_idle ? ST_BEGIN : ST_REPLY);
                    OP_WRITE,
                    OP_READ_ACK,
                    OP_READ_NACK: state_d = owned ? ST_SHIFT : ST_REPLY;
                    OP_STOP:      state_d = owned ? ST_END : ST_REPLY;
                    default:      state_d = ST_IDLE;
                endcase
            end
            ST_BEGIN, ST_RESUME, ST_END:
                if (tick && ph == 2'd3) state_d = ST_REPLY;
            ST_SHIFT: begin
                if (tick && ph == 2'd2 && arb_lose)               state_d = ST_REPLY;
                else if (tick && ph == 2'd3 && bitn == '0)        state_d = ST_REPLY;
            end
            ST_REPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // datapath and line outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= '0; bitn <= '0; txsr <= '0; rxsr <= '0;
            rd <= 1'b0; owned <= 1'b0; first <= 1'b0;
            lost_q <= 1'b0; nack_q <= 1'b0; ext_q <= 1'b0;
            scl_oe <= 1'b0; sda_oe <= 1'b0;
        end else begin
            if (state == ST_IDLE || state == ST_REPLY) ph <= '0;
            else if (tick)                             ph <= ph + 2'd1;

            if (accept && op != OP_NOP && cmd_op <= 3'd5) begin
                lost_q <= 1'b0;
                nack_q <= !owned && (op != OP_START);
                ext_q  <= 1'b0;
                unique case (op)
                    OP_START: lost_q <= !owned && !bus_idle;
                    OP_WRITE: begin
                        txsr  <= {cmd_data, 1'b1};
                        rd    <= 1'b0;
                        bitn  <= BW'(BITS-1);
                        ext_q <= owned && first && (cmd_data[7:3] == EXT_PREFIX);
                    end
                    OP_READ_ACK, OP_READ_NACK: begin
                        txsr <= {8'hFF, op == OP_READ_NACK};
                        rd   <= 1'b1;
                        bitn <= BW'(BITS-1);
                    end
                    default: ;
                endcase
            end

            if (tick) begin
                unique case (state)
                    ST_BEGIN: begin
                        if (ph == 2'd0) sda_oe <= 1'b1;
                        if (ph == 2'd2) scl_oe <= 1'b1;
                        if (ph == 2'd3) begin owned <= 1'b1; first <= 1'b1; end
                    end
                    ST_RESUME: begin
                        if (ph == 2'd0) sda_oe <= 1'b0;
                        if (ph == 2'd1) scl_oe <= 1'b0;
                        if (ph == 2'd2) sda_oe <= 1'b1;
                        if (ph == 2'd3) begin scl_oe <= 1'b1; first <= 1'b1; end
                    end
                    ST_SHIFT: begin
                        if (ph == 2'd0) sda_oe <= !txsr[8];
                        if (ph == 2'd1) scl_oe <= 1'b0;
                        if (ph == 2'd2) begin
                            if (arb_lose) begin
                                lost_q <= 1'b1; owned <= 1'b0;
                                sda_oe <= 1'b0; scl_oe <= 1'b0;
                            end else if (bitn == '0) nack_q <= sda_s;
                            else                     rxsr   <= {rxsr[6:0], sda_s};
                        end
                        if (ph == 2'd3) begin
                            scl_oe <= 1'b1;
                            txsr   <= {txsr[7:0], 1'b0};
                            bitn   <= bitn - 1'b1;
                            if (bitn == '0) first <= 1'b0;
                        end
                    end
                    ST_END: begin
                        if (ph == 2'd0) sda_oe <= 1'b1;
                        if (ph == 2'd1) scl_oe <= 1'b0;
                        if (ph == 2'd2) sda_oe <= 1'b0;
                        if (ph == 2'd3) owned  <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign cmd_ready = (state == ST_IDLE);
    assign rsp_valid = (state == ST_REPLY);
    assign rsp_data  = rxsr;
    assign rsp_nack  = nack_q;
    assign rsp_ext   = ext_q;
    assign rsp_lost  = lost_q;

    // R1: a controller that does not hold the bus drives neither line while idle
    p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !owned) |-> (!scl_oe && !sda_oe));
    // R2: the clock enable rises in a start only after the data line is pulled low
    p_start_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BEGIN && $rose(scl_oe)) |-> sda_oe);
    // R3: during a transfer the data enable holds while the clock is released
    p_sda_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && $past(state == ST_SHIFT) && !$past(scl_oe)) |-> $stable(sda_oe));
    // R7: the data line is released in a stop only after the clock is released
    p_stop_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_END && $fell(sda_oe)) |-> !scl_oe);
    // R9: a lost response comes with both lines released
    p_lost_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_lost) |-> (!scl_oe && !sda_oe));
    // R11: a response lasts one cycle and the block is busy while it is shown
    p_one_reply_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!cmd_ready ##1 !rsp_valid));
endmodule

// File: tb/twi_master_tb.sv
`timescale 1ns/1ps
module twi_master_tb;
    localparam int DIV_W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [DIV_W-1:0] div = 12'd3;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [7:0] cmd_data = 8'd0;
    logic cmd_ready, rsp_valid, rsp_nack, rsp_ext, rsp_lost, scl_oe, sda_oe;
    logic [7:0] rsp_data;

    // peripheral model state
    logic per_low = 1'b0, ext_low = 1'b0, per_rd = 1'b0, per_nack = 1'b0, per_kill = 1'b0;
    logic [7:0] per_tx = 8'd0, per_shift = 8'd0;
    logic per_mack = 1'b0;
    logic [3:0] pbit = 4'd0;
    int starts = 0, stops = 0, hi_cnt = 0, hi_len = 0;
    logic scl_p = 1'b1, sda_p = 1'b1;

    wire scl_line = !scl_oe;
    wire sda_line = !(sda_oe || per_low || ext_low);

    twi_master #(.DIV_W(DIV_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .div(div),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_nack(rsp_nack),
        .rsp_ext(rsp_ext), .rsp_lost(rsp_lost),
        .scl_in(scl_line), .scl_oe(scl_oe), .sda_in(sda_line), .sda_oe(sda_oe)
    );

    always @(negedge clk) begin
        scl_p <= scl_line;
        sda_p <= sda_line;
        if (scl_line) hi_cnt <= hi_cnt + 1;
        if (scl_p && scl_line && sda_p && !sda_line) begin starts <= starts + 1; pbit <= 4'd0; end
        if (scl_p && scl_line && !sda_p && sda_line) stops <= stops + 1;
        if (!scl_p && scl_line) begin
            if (pbit < 4'd8) per_shift <= {per_shift[6:0], sda_line};
            else             per_mack  <= sda_line;
            pbit <= (pbit == 4'd8) ? 4'd0 : pbit + 4'd1;
        end
        if (scl_p && !scl_line) begin hi_len <= hi_cnt; hi_cnt <= 0; end
        if (per_kill) per_low <= 1'b0;
        else if (!scl_line)
            per_low <= per_rd ? ((pbit < 4'd8) && !per_tx[3'(7 - pbit)])
                              : ((pbit == 4'd8) && !per_nack);
    end

    int tests = 0, fails = 0;
    logic [7:0] r_data;
    logic r_nack, r_ext, r_lost;

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [7:0] d);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        r_data = rsp_data; r_nack = rsp_nack; r_ext = rsp_ext; r_lost = rsp_lost;
    endtask

    function automatic logic exp_ext(input logic first, input logic [7:0] b);
        return first && (b[7:3] == 5'b11110);
    endfunction

    task automatic idle_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all requirements actual=hang expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int s0, t0;
        void'($urandom(32'h5EED_2B1F));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 scl_oe", scl_oe, 0);
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 cmd_ready", cmd_ready, 1);
        chk("R1 rsp_valid", rsp_valid, 0);

        // directed transaction
        s0 = starts; t0 = stops;
        issue(3'd1, 8'h00);
        chk("R2 start seen", starts, s0 + 1);
        chk("R2 not lost", r_lost, 0);
        per_nack = 1'b0;
        issue(3'd2, 8'hA4);
        chk("R4 byte on bus", per_shift, 8'hA4);
        chk("R4 ack", r_nack, 0);
        chk("R10 scl high div3", hi_len, 8);
        per_nack = 1'b1;
        issue(3'd2, 8'h3C);
        chk("R4 byte on bus", per_shift, 8'h3C);
        chk("R4 nack", r_nack, 1);
        per_nack = 1'b0;
        issue(3'd1, 8'h00);
        chk("R6 restart seen", starts, s0 + 2);
        chk("R6 no stop", stops, t0);
        issue(3'd2, 8'hA5);
        per_rd = 1'b1; per_tx = 8'h5A;
        issue(3'd3, 8'h00);
        chk("R5 read data", r_data, 8'h5A);
        chk("R5 master ack", per_mack, 0);
        per_tx = 8'hC3;
        issue(3'd4, 8'h00);
        chk("R5 read data", r_data, 8'hC3);
        chk("R5 master nack", per_mack, 1);
        per_rd = 1'b0;
        issue(3'd5, 8'h00);
        chk("R7 stop seen", stops, t0 + 1);
        idle_wait(3);
        chk("R7 lines released", {scl_line, sda_line}, 2'b11);
        chk("R3 start count", starts, s0 + 2);

        // R8 extended prefix
        issue(3'd1, 8'h00);
        issue(3'd2, 8'hF2);
        chk("R8 prefix first", r_ext, 1);
        issue(3'd2, 8'hF6);
        chk("R8 prefix later", r_ext, 0);
        issue(3'd1, 8'h00);
        issue(3'd2, 8'hF1);
        chk("R8 prefix after restart", r_ext, 1);
        issue(3'd1, 8'h00);
        issue(3'd2, 8'hE8);
        chk("R8 non prefix", r_ext, 0);
        issue(3'd5, 8'h00);

        // R11 commands with no bus held, ignored ops and pulses while busy
        s0 = starts; t0 = stops;
        issue(3'd2, 8'h55);
        chk("R11 rejected write", r_nack, 1);
        chk("R11 rejected not lost", r_lost, 0);
        issue(3'd5, 8'h00);
        chk("R11 rejected stop", r_nack, 1);
        chk("R11 no start", starts, s0);
        chk("R11 no stop", stops, t0);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd6; cmd_data = 8'h00;
        @(negedge clk);
        cmd_valid = 1'b0;
        idle_wait(2);
        chk("R11 op6 ignored ready", cmd_ready, 1);
        chk("R11 op6 no reply", rsp_valid, 0);
        issue(3'd1, 8'h00);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd2; cmd_data = 8'h96;
        @(negedge clk);
        cmd_op = 3'd5; cmd_data = 8'h00;
        idle_wait(20);
        cmd_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        chk("R11 busy pulse ignored", per_shift, 8'h96);
        chk("R11 busy no stop", stops, t0);
        issue(3'd5, 8'h00);

        // R9 arbitration loss against a rival pulling a 0
        issue(3'd1, 8'h00);
        per_rd = 1'b1; per_tx = 8'hEF;
        issue(3'd2, 8'hFF);
        chk("R9 lost flag", r_lost, 1);
        chk("R9 scl released", scl_oe, 0);
        chk("R9 sda released", sda_oe, 0);
        @(negedge clk);
        chk("R9 back to idle", cmd_ready, 1);
        per_rd = 1'b0; per_kill = 1'b1;
        idle_wait(4);
        per_kill = 1'b0;
        idle_wait(4);
        s0 = starts;
        issue(3'd1, 8'h00);
        chk("R9 fresh start after loss", starts, s0 + 1);
        chk("R9 fresh start not lost", r_lost, 0);
        issue(3'd5, 8'h00);

        // R12 start on a busy bus
        ext_low = 1'b1;
        idle_wait(5);
        s0 = starts;
        issue(3'd1, 8'h00);
        chk("R12 busy start lost", r_lost, 1);
        chk("R12 lines untouched", {scl_oe, sda_oe}, 2'b00);
        chk("R12 no extra start", starts, s0);
        ext_low = 1'b0;
        idle_wait(5);

        // seeded random transactions
        for (int t = 0; t < 30; t++) begin
            logic [6:0] addr;
            logic rw;
            int n;
            logic [7:0] b;
            div = DIV_W'(3 + $urandom_range(0, 4));
            addr = 7'($urandom_range(0, 127));
            rw = 1'($urandom_range(0, 1));
            s0 = starts; t0 = stops;
            issue(3'd1, 8'h00);
            chk("R2 random start", starts, s0 + 1);
            per_rd = 1'b0; per_nack = 1'b0;
            b = {addr, rw};
            issue(3'd2, b);
            chk("R4 random address", per_shift, b);
            chk("R4 random address ack", r_nack, 0);
            chk("R8 random address flag", r_ext, exp_ext(1'b1, b));
            chk("R10 random scl high", hi_len, 2 * (int'(div) + 1));
            n = $urandom_range(1, 3);
            for (int k = 0; k < n; k++) begin
                if (rw) begin
                    per_rd = 1'b1; per_tx = 8'($urandom_range(0, 255));
                    issue((k == n - 1) ? 3'd4 : 3'd3, 8'h00);
                    chk("R5 random read", r_data, per_tx);
                    chk("R5 random master ack", per_mack, (k == n - 1) ? 1 : 0);
                end else begin
                    per_nack = 1'($urandom_range(0, 1));
                    b = 8'($urandom_range(0, 255));
                    issue(3'd2, b);
                    chk("R4 random data", per_shift, b);
                    chk("R4 random ack", r_nack, per_nack);
                    chk("R8 random later flag", r_ext, 0);
                end
            end
            per_rd = 1'b0;
            if ($urandom_range(0, 1) == 1) begin
                issue(3'd1, 8'h00);
                chk("R6 random restart", starts, s0 + 2);
                chk("R6 random no stop", stops, t0);
                issue(3'd5, 8'h00);
                chk("R3 random starts", starts, s0 + 2);
            end else begin
                issue(3'd5, 8'h00);
                chk("R3 random starts", starts, s0 + 1);
            end
            chk("R7 random stop", stops, t0 + 1);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule